// File: doc/BRIEF.md
# Block DMA Engine (Memory to I/O)

This engine copies a run of bytes from a 16-bit byte-addressed memory into a single fixed I/O data port. A processor programs it through four byte-wide, write-only configuration registers placed at the top of the address map. Two of them hold a 16-bit byte count and two hold a 16-bit source address. The write to the upper source-address byte is the start command. If the programmed count is non-zero, the engine raises a hold request. It waits until the processor answers with hold acknowledge, and only then takes over the bus.

While it owns the bus, the engine repeats a two-cycle step. In the first cycle it issues a memory read at the current source address. In the second cycle it forwards the returned byte to the I/O port. After each step the address advances and the remaining count shrinks. When the count runs out, the engine drops its hold request. It then waits for the acknowledge to fall before it reports itself idle. The processor stays held for the whole block. The memory returns read data one clock after the read strobe. The processor is expected to keep hold acknowledge high until the engine drops its request.

Top module: `dma_blk_mover`

## Requirements
- R1: Register writes are decoded on the full 16-bit configuration address. 0xFFF4 is the source-address low byte and 0xFFF5 is the source-address high byte (start). 0xFFF6 is the length low byte and 0xFFF7 is the length high byte. A write to any other address changes nothing.
- R2: After reset, hold_req, busy, mem_rd_en and io_wr_en are all low.
- R3: A write to 0xFFF5 while idle with a non-zero programmed length raises hold_req and busy on the next clock. The source address becomes {written byte, address-low register}.
- R4: mem_rd_en and io_wr_en are never high unless both hold_req and hold_ack are high.
- R5: Each byte is read at the current address with mem_rd_en. The next cycle writes the returned byte on io_wdata with io_wr_en. The address then increments modulo 65536, so 0xFFFF is followed by 0x0000.
- R6: Exactly the programmed number of bytes (1 to 65535) is read and written. hold_req falls in the cycle after the last I/O write.
- R7: A start with a programmed length of zero raises neither hold_req nor busy and performs no bus access.
- R8: Register writes, including a write to 0xFFF5, are ignored while busy is high. The running transfer is unaffected, and the length register keeps its value for the next start.
- R9: busy is high from the cycle hold_req rises until the cycle after hold_ack is seen low following the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 16 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| hold_req | output | 1 | Bus hold request to the processor |
| hold_ack | input | 1 | Bus hold acknowledge from the processor |
| busy | output | 1 | Transfer in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address, zero when not reading |
| mem_rdata | input | 8 | Memory read data, valid one clock after mem_rd_en |
| io_wr_en | output | 1 | I/O port write strobe |
| io_wdata | output | 8 | I/O port write data, zero when not writing |

## Verification
Some properties are checked on every cycle. Bus strobes appear only inside an acknowledged hold. Each read address is one above the previous read. The request rises one clock after a non-zero start, and a zero-length start leaves the engine idle. The request only ever falls after an I/O write. busy falls only after the acknowledge has dropped. Writes during a transfer leave the configuration registers untouched. Other properties need the bench's scenarios: the exact byte count, the data carried per address, wrap past 0xFFFF, full-address decoding that rejects aliasing offsets, and a stored length that survives an ignored write and is reused on the next start.

// File: rtl/dmx_pkg.sv
// Package: shared types and register offsets for the block DMA engine.
// Assumes byte-wide configuration registers laid out from a common base.
package dmx_pkg;

    // Sequencer states: idle, waiting for the bus, read phase, write phase, release.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_REL  = 3'd4
    } dmx_state_e;

    // Offsets from the register base; the source-high offset is the start command.
    localparam int unsigned OFS_SRC_LO = 0;
    localparam int unsigned OFS_SRC_HI = 1;
    localparam int unsigned OFS_LEN_LO = 2;
    localparam int unsigned OFS_LEN_HI = 3;
    localparam int unsigned NUM_REGS   = 4;

endpackage

// File: rtl/dmx_cfg_regs.sv
// Module: configuration register file of the block DMA engine.
// Decodes full-width write addresses, stores the source-low byte and the
// length, and turns a write to the source-high offset into a start pulse.
// Assumes writes are single-cycle strobes; all writes are dropped while busy.
module dmx_cfg_regs
    import dmx_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned REG_BASE = 'hFFF4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2*DATA_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic                  busy,
    output logic                  start,
    output logic [2*DATA_W-1:0]   src_addr,
    output logic [2*DATA_W-1:0]   xfer_len
);
    localparam int unsigned WORD_W = 2 * DATA_W;
    localparam int unsigned BYTES  = WORD_W / DATA_W;

    logic [WORD_W-1:0] ofs;
    logic [1:0]        sel;
    logic              wr_ok;
    logic [DATA_W-1:0] src_lo_q;
    logic [WORD_W-1:0] len_q;

    // Offset of the write from the register base and its acceptance.
    always_comb begin
        ofs   = cfg_addr - WORD_W'(REG_BASE);
        sel   = ofs[1:0];
        wr_ok = cfg_we && !busy && (ofs < WORD_W'(NUM_REGS));
    end

    // Source-address low byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                              src_lo_q <= '0;
        else if (wr_ok && sel == 2'(OFS_SRC_LO)) src_lo_q <= cfg_wdata;
    end

    // One storage byte per length slice, low byte first.
    for (genvar b = 0; b < BYTES; b++) begin : g_len
        always_ff @(posedge clk) begin
            if (!rst_n)
                len_q[b*DATA_W +: DATA_W] <= '0;
            else if (wr_ok && sel == 2'(OFS_LEN_LO + b))
                len_q[b*DATA_W +: DATA_W] <= cfg_wdata;
        end
    end

    // Start pulse and the address it launches.
    always_comb begin
        start    = wr_ok && (sel == 2'(OFS_SRC_HI));
        src_addr = {cfg_wdata, src_lo_q};
        xfer_len = len_q;
    end

    // R8: configuration storage must not move while a transfer runs.
    assert_busy_write_ignored_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> ($stable(len_q) && $stable(src_lo_q)));

endmodule

// File: rtl/dmx_xfer_fsm.sv
// Module: transfer sequencer of the block DMA engine.
// Owns the hold handshake, the running address and the remaining count.
// Assumes hold_ack stays high from its rise until hold_req falls.
module dmx_xfer_fsm
    import dmx_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] src_addr,
    input  logic [WORD_W-1:0] xfer_len,
    input  logic              hold_ack,
    output logic              hold_req,
    output logic              busy,
    output logic              rd_phase,
    output logic              wr_phase,
    output logic [WORD_W-1:0] cur_addr
);
    dmx_state_e        st_q, st_d;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] remain_q;
    logic              last_byte;

    // Next-state selection.
    always_comb begin
        st_d      = st_q;
        last_byte = (remain_q == WORD_W'(1));
        unique case (st_q)
            ST_IDLE: if (start && xfer_len != '0) st_d = ST_REQ;
            ST_REQ:  if (hold_ack)               st_d = ST_RD;
            ST_RD:   if (hold_ack)               st_d = ST_WR;
            ST_WR:   if (hold_ack)               st_d = last_byte ? ST_REL : ST_RD;
            ST_REL:  if (!hold_ack)              st_d = ST_IDLE;
            default:                             st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Address and count: load on start, step after each forwarded byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
        end else if (st_q == ST_IDLE && start && xfer_len != '0) begin
            addr_q   <= src_addr;
            remain_q <= xfer_len;
        end else if (st_q == ST_WR && hold_ack) begin
            addr_q   <= addr_q + WORD_W'(1);
            remain_q <= remain_q - WORD_W'(1);
        end
    end

    // Decoded outputs.
    always_comb begin
        hold_req = (st_q == ST_REQ) || (st_q == ST_RD) || (st_q == ST_WR);
        busy     = (st_q != ST_IDLE);
        rd_phase = (st_q == ST_RD);
        wr_phase = (st_q == ST_WR);
        cur_addr = addr_q;
    end

    // R3: an accepted start with a non-zero length requests the bus next cycle.
    assert_start_requests_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (start && xfer_len != '0) |=> (hold_req && busy));

    // R7: a zero-length start leaves the engine idle.
    assert_zero_len_idle_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (start && xfer_len == '0) |=> (!hold_req && !busy));

    // R6: the request is withdrawn only right after an I/O write phase.
    assert_release_after_write_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(hold_req) |-> $past(wr_phase));

    // R9: busy ends only after the request is gone and the acknowledge dropped.
    assert_busy_until_ack_low_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!$past(hold_req) && !$past(hold_ack)));

endmodule

// File: rtl/dmx_bus_drive.sv
// Module: bus output stage of the block DMA engine.
// Gates strobes with the acknowledge and parks address and data at zero
// whenever the engine is not actively driving.
// Assumes memory read data arrives one clock after the read strobe.
module dmx_bus_drive #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WORD_W = 16
) (
    input  logic              rd_phase,
    input  logic              wr_phase,
    input  logic              hold_ack,
    input  logic [WORD_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd_en,
    output logic [WORD_W-1:0] mem_addr,
    output logic              io_wr_en,
    output logic [DATA_W-1:0] io_wdata
);
    // Strobe gating and zero-parking of the driven buses.
    always_comb begin
        mem_rd_en = rd_phase && hold_ack;
        io_wr_en  = wr_phase && hold_ack;
        mem_addr  = mem_rd_en ? cur_addr  : '0;
        io_wdata  = io_wr_en  ? mem_rdata : '0;
    end

endmodule

// File: rtl/dma_blk_mover.sv
// Module: top of the block DMA engine (memory to a fixed I/O port).
// Connects the register file, the sequencer and the bus output stage.
// Assumes a processor that honours the hold handshake and a memory with
// one-cycle read latency.
module dma_blk_mover #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned REG_BASE = 'hFFF4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2*DATA_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic                hold_req,
    input  logic                hold_ack,
    output logic                busy,
    output logic                mem_rd_en,
    output logic [2*DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                io_wr_en,
    output logic [DATA_W-1:0]   io_wdata
);
    localparam int unsigned WORD_W = 2 * DATA_W;

    logic              start;
    logic [WORD_W-1:0] src_addr;
    logic [WORD_W-1:0] xfer_len;
    logic              rd_phase;
    logic              wr_phase;
    logic [WORD_W-1:0] cur_addr;

    dmx_cfg_regs #(.DATA_W(DATA_W), .REG_BASE(REG_BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .start     (start),
        .src_addr  (src_addr),
        .xfer_len  (xfer_len)
    );

    dmx_xfer_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .src_addr (src_addr),
        .xfer_len (xfer_len),
        .hold_ack (hold_ack),
        .hold_req (hold_req),
        .busy     (busy),
        .rd_phase (rd_phase),
        .wr_phase (wr_phase),
        .cur_addr (cur_addr)
    );

    dmx_bus_drive #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_bus (
        .rd_phase  (rd_phase),
        .wr_phase  (wr_phase),
        .hold_ack  (hold_ack),
        .cur_addr  (cur_addr),
        .mem_rdata (mem_rdata),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .io_wr_en  (io_wr_en),
        .io_wdata  (io_wdata)
    );

    // R4: no bus strobe outside a granted hold.
    assert_no_drive_without_hold_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mem_rd_en || io_wr_en) |-> (hold_req && hold_ack));

    // R5: each read after a write step is one address above the previous read.
    assert_addr_steps_by_one_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(io_wr_en)) |-> (mem_addr == $past(mem_addr, 2) + WORD_W'(1)));

endmodule

// File: tb/tb_dma_blk_mover.sv
// Bench: sweeps lengths, start addresses and acknowledge delays, checking the
// byte stream against an address-derived memory pattern.
module tb_dma_blk_mover;
    localparam logic [15:0] BASE = 16'hFFF4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        hold_ack = 1'b0;
    logic        hold_req, busy, mem_rd_en, io_wr_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  io_wdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Monitor totals, written only by the monitor process.
    int          nrd = 0, nwr = 0, nbad = 0, nviol = 0;
    logic [7:0]  pend = '0;
    // Snapshot taken by the stimulus before each start.
    logic [15:0] base_addr = '0;
    int          snap_rd = 0;

    always #2.5 clk = ~clk;

    dma_blk_mover dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hold_req(hold_req), .hold_ack(hold_ack),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .io_wr_en(io_wr_en), .io_wdata(io_wdata)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hA5;
    endfunction

    // Memory model with one-cycle read latency.
    always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(mem_addr);

    // Bus monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (mem_rd_en) begin
            if (mem_addr !== base_addr + 16'(nrd - snap_rd)) nbad++;
            pend = pat(base_addr + 16'(nrd - snap_rd));
            nrd++;
        end
        if (io_wr_en) begin
            if (io_wdata !== pend) nbad++;
            nwr++;
        end
        if ((mem_rd_en || io_wr_en) && !(hold_ack && hold_req)) nviol++;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog act=%0d exp<=150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One block transfer; optionally programs the length and pokes registers mid-run.
    task automatic run_xfer(input logic [15:0] src, input logic [15:0] len,
                            input int ack_dly, input bit set_len, input bit poke);
        int wr0, bad0, viol0, t;
        if (set_len) begin
            cfg_write(BASE + 16'd2, len[7:0]);
            cfg_write(BASE + 16'd3, len[15:8]);
        end
        cfg_write(BASE, src[7:0]);
        @(negedge clk);
        base_addr = src; snap_rd = nrd; wr0 = nwr; bad0 = nbad; viol0 = nviol;
        cfg_write(BASE + 16'd1, src[15:8]);
        chk(hold_req === 1'b1, "R3 hold_req after start", int'(hold_req), 1);
        chk(busy === 1'b1, "R9 busy with request", int'(busy), 1);
        for (int i = 0; i < ack_dly; i++) @(negedge clk);
        hold_ack = 1'b1;
        if (poke) begin
            repeat (3) @(negedge clk);
            cfg_write(BASE + 16'd1, 8'h77);
            cfg_write(BASE + 16'd2, 8'h01);
            cfg_write(BASE + 16'd3, 8'h00);
        end
        t = 0;
        while (hold_req && t < 2 * int'(len) + 20) begin
            @(negedge clk);
            t++;
        end
        chk(hold_req === 1'b0, "R6 request released", int'(hold_req), 0);
        chk(busy === 1'b1, "R9 busy until ack drops", int'(busy), 1);
        hold_ack = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R9 idle after ack drop", int'(busy), 0);
        chk(nrd - snap_rd == int'(len), "R6 reads", nrd - snap_rd, int'(len));
        chk(nwr - wr0 == int'(len), "R6 io writes", nwr - wr0, int'(len));
        chk(nbad == bad0, "R5 address/data mismatches", nbad - bad0, 0);
        chk(nviol == viol0, "R4 strobes outside hold", nviol - viol0, 0);
    endtask

    initial begin
        logic [15:0] addrs [4];
        addrs[0] = 16'h0000; addrs[1] = 16'h00FF; addrs[2] = 16'h7FFE; addrs[3] = 16'hFFFC;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hold_req === 1'b0, "R2 reset hold_req", int'(hold_req), 0);
        chk(busy === 1'b0, "R2 reset busy", int'(busy), 0);
        chk(mem_rd_en === 1'b0 && io_wr_en === 1'b0, "R2 reset strobes",
            int'(mem_rd_en) + int'(io_wr_en), 0);

        // Sweep of start addresses, lengths and acknowledge latency (R5 R6 wrap).
        for (int a = 0; a < 4; a++)
            for (int l = 1; l <= 8; l++)
                run_xfer(addrs[a], 16'(l), l % 3, 1'b1, 1'b0);

        // Wrap past the top of memory (R5).
        run_xfer(16'hFFFE, 16'd5, 0, 1'b1, 1'b0);
        // Length with a non-zero high byte (R6).
        run_xfer(16'h1234, 16'd300, 2, 1'b1, 1'b0);

        // Zero length: no request at all (R7).
        cfg_write(BASE + 16'd2, 8'h00);
        cfg_write(BASE + 16'd3, 8'h00);
        cfg_write(BASE, 8'h10);
        cfg_write(BASE + 16'd1, 8'h20);
        for (int i = 0; i < 4; i++) begin
            chk(!hold_req && !busy && !mem_rd_en, "R7 zero length stays idle",
                int'(hold_req) + int'(busy) + int'(mem_rd_en), 0);
            @(negedge clk);
        end

        // Writes during a transfer are ignored; stored length reused (R8).
        run_xfer(16'h1200, 16'd6, 1, 1'b1, 1'b1);
        run_xfer(16'h4000, 16'd6, 0, 1'b0, 1'b0);

        // Aliasing addresses must not reach the registers (R1).
        cfg_write(BASE + 16'd2, 8'h03);
        cfg_write(BASE + 16'd3, 8'h00);
        cfg_write(16'hFFFA, 8'h00);
        cfg_write(16'hFFF2, 8'h09);
        cfg_write(16'h7FF6, 8'h0F);
        run_xfer(16'h5500, 16'd3, 1, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule